// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block turns an enable, two direction bits and a chop request into the four gate commands of one H-bridge. The bridge has two legs, and each leg has a high switch and a low switch. The block decodes the drive mode: off, forward, reverse, brake through the low switches, or brake through the high switches. Each leg then gets a target switch. A small sequencer per leg moves the gate outputs to that target, and it never lets a leg go from one switch to its partner without a fixed gap in which both switches are off.

The chop request comes from a constant-off-time current controller. While it is asserted in forward or reverse, the leg that is held at ground gives up its low switch. After the gap, that leg closes its high switch, so the load current circulates through the two upper switches as synchronous rectification. When the request drops, the high switch opens and the low switch closes again one gap later.

Each leg also raises a one-cycle marker in the cycle its low switch turns on. The current controller uses this marker to start its blanking window.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `en` is low, all four gate outputs are off from the first clock edge that samples it, whatever `dir1`, `dir2` and `chop` are.
- R2: With `en` high and `dir1`=`dir2`=0, both low gates turn on and both high gates stay off. `chop` has no effect in this mode.
- R3: With `en` high and `dir1`=`dir2`=1, both high gates turn on and both low gates stay off. `chop` has no effect in this mode.
- R4: Vector bit 0 is the output-1 leg and bit 1 is the output-2 leg. With `dir1`=1 and `dir2`=0 (forward), leg 0 drives its high gate and leg 1 drives its low gate. With `dir1`=0 and `dir2`=1 (reverse), the assignment is mirrored.
- R5: A gate that is no longer requested turns off at the first edge that samples the new request. A leg turns a gate on only after it has spent exactly `DEAD_CYC` consecutive cycles with both gates off, counted from that edge. A leg never turns on a gate with fewer off cycles than that, and a gate that is still requested stays on.
- R6: In forward or reverse with `chop` high, the grounded leg opens its low gate at the next edge and closes its high gate `DEAD_CYC` cycles later. When `chop` falls, that high gate opens at the next edge and the low gate closes `DEAD_CYC` cycles later.
- R7: If a leg's target changes while it is in its off gap, the gap restarts. The gate turns on `DEAD_CYC` cycles after the edge that sampled the last change, and the other leg is not affected.
- R8: Bit n of `lo_on_pulse` is high for exactly one cycle. That cycle is the first cycle in which `gate_lo[n]` is on.
- R9: During and right after reset, all gates and markers are low. The first turn-on after reset also waits the full `DEAD_CYC` gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bridge enable; low turns off all switches |
| dir1 | input | 1 | Direction bit for output 1 |
| dir2 | input | 1 | Direction bit for output 2 |
| chop | input | 1 | Off-phase request from the current chopper |
| gate_hi | output | 2 | High-switch gate commands, bit 0 = output-1 leg |
| gate_lo | output | 2 | Low-switch gate commands, bit 0 = output-1 leg |
| lo_on_pulse | output | 2 | One-cycle marker per leg when its low switch turns on |

## Verification
If the inputs are sampled at edge k, every turn-off is due in the cycle after edge k. Every turn-on is due after edge k+`DEAD_CYC` and not one cycle earlier. The low-switch marker is due in the same cycle as its turn-on. For each stimulus, the driver queues expected gate and marker values, each tagged with the cycle number in which it is due. This includes the still-off cycle just before each turn-on, which pins the gap length exactly. The monitor samples on the falling edge, compares only the items due in that cycle, and reports any item that has gone stale. A gap restart is checked by changing one leg's target in mid-gap and expecting each leg's turn-on at its own cycle.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Switch selection for one leg
  typedef enum logic [1:0] {
    SW_OFF  = 2'd0,
    SW_HIGH = 2'd1,
    SW_LOW  = 2'd2
  } sw_e;

  localparam int unsigned LEGS = 2;

endpackage

// File: rtl/hbg_mode_map.sv
module hbg_mode_map
  import hbg_pkg::*;
(
  input  logic en,
  input  logic dir1,
  input  logic dir2,
  input  logic chop,
  output sw_e  leg_req [LEGS]
);

  always_comb begin
    leg_req[0] = SW_OFF;
    leg_req[1] = SW_OFF;
    if (en) begin
      case ({dir1, dir2})
        2'b00: begin            // brake through lower switches
          leg_req[0] = SW_LOW;
          leg_req[1] = SW_LOW;
        end
        2'b11: begin            // brake through upper switches
          leg_req[0] = SW_HIGH;
          leg_req[1] = SW_HIGH;
        end
        2'b10: begin            // forward; grounded leg recirculates on chop
          leg_req[0] = SW_HIGH;
          leg_req[1] = chop ? SW_HIGH : SW_LOW;
        end
        default: begin          // reverse
          leg_req[0] = chop ? SW_HIGH : SW_LOW;
          leg_req[1] = SW_HIGH;
        end
      endcase
    end
  end

endmodule

// File: rtl/hbg_leg_seq.sv
module hbg_leg_seq
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  sw_e  req,
  output logic gate_hi,
  output logic gate_lo,
  output logic lo_pulse
);

  localparam int unsigned     CW       = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0]   GAP_LAST = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0]   GAP_FULL = CW'(DEAD_CYC);

  sw_e           drv_q, drv_n;
  sw_e           last_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pulse_n;
  logic          drv_en, cnt_en;

  // Next-state: open at once, close only after a full, unbroken gap
  always_comb begin
    drv_n = drv_q;
    cnt_n = cnt_q;
    if (drv_q != SW_OFF) begin
      if (req != drv_q) begin
        drv_n = SW_OFF;
        cnt_n = '0;
      end
    end else if (req == SW_OFF || req != last_q) begin
      cnt_n = '0;
    end else if (cnt_q == GAP_LAST) begin
      drv_n = req;
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
    pulse_n = (drv_n == SW_LOW) && (drv_q != SW_LOW);
  end

  assign drv_en = (drv_n != drv_q);
  assign cnt_en = (cnt_n != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q    <= SW_OFF;
      last_q   <= SW_OFF;
      cnt_q    <= '0;
      lo_pulse <= 1'b0;
    end else begin
      if (drv_en) drv_q <= drv_n;
      if (cnt_en) cnt_q <= cnt_n;
      last_q   <= req;
      lo_pulse <= pulse_n;
    end
  end

  assign gate_hi = (drv_q == SW_HIGH);
  assign gate_lo = (drv_q == SW_LOW);

  // Checker: independent count of consecutive all-off cycles
  logic [CW-1:0] off_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run_q <= '0;
    end else if (!(gate_hi || gate_lo)) begin
      if (off_run_q != GAP_FULL) off_run_q <= off_run_q + CW'(1);
    end else begin
      off_run_q <= '0;
    end
  end

  // R5, R9: no turn-on without a full gap
  a_r5_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi || gate_lo) && !$past(gate_hi || gate_lo)) |-> (off_run_q == GAP_FULL));

  // R5: a still-requested switch stays on
  a_r5_hold_on: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_q != SW_OFF && req == drv_q) |=> $stable(drv_q));

  // R8: marker only on the first low-on cycle
  a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    lo_pulse |-> (gate_lo && !$past(gate_lo)));

  // R8: every low turn-on is marked
  a_r8_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_lo && !$past(gate_lo)) |-> lo_pulse);

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir1,
  input  logic             dir2,
  input  logic             chop,
  output logic [LEGS-1:0]  gate_hi,
  output logic [LEGS-1:0]  gate_lo,
  output logic [LEGS-1:0]  lo_on_pulse
);

  sw_e leg_req [LEGS];

  hbg_mode_map u_map (
    .en      (en),
    .dir1    (dir1),
    .dir2    (dir2),
    .chop    (chop),
    .leg_req (leg_req)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hbg_leg_seq #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (leg_req[g]),
      .gate_hi  (gate_hi[g]),
      .gate_lo  (gate_lo[g]),
      .lo_pulse (lo_on_pulse[g])
    );
  end

  // R1: disabled bridge has every switch open one edge later
  a_r1_disable_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/hbridge_gate_seq_bench.sv
module hbridge_gate_seq_bench;

  localparam int D = 4;

  logic       clk, rst_n, en, dir1, dir2, chop;
  logic [1:0] gate_hi, gate_lo, lo_on_pulse;

  hbridge_gate_seq #(.DEAD_CYC(D)) u_hbridge_gate_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .dir1        (dir1),
    .dir2        (dir2),
    .chop        (chop),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .lo_on_pulse (lo_on_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int         due;
    logic [1:0] h;
    logic [1:0] l;
    logic [1:0] p;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic compare(item_t it);
    n_cmp++;
    if (gate_hi !== it.h || gate_lo !== it.l || lo_on_pulse !== it.p) begin
      n_bad++;
      $display("FAIL %s @cyc %0d: hi=%b lo=%b pulse=%b expected hi=%b lo=%b pulse=%b",
               it.tag, cyc, gate_hi, gate_lo, lo_on_pulse, it.h, it.l, it.p);
    end
  endtask

  // Monitor: pops items as they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.due < cyc) begin
        n_cmp++;
        n_bad++;
        $display("FAIL %s: item for cyc %0d stale at cyc %0d, expected on time",
                 it.tag, it.due, cyc);
      end else begin
        compare(it);
      end
    end
  end

  task automatic apply(logic e, logic a, logic b, logic c);
    en = e; dir1 = a; dir2 = b; chop = c;
  endtask

  task automatic exp_at(int off, logic [1:0] h, logic [1:0] l, logic [1:0] p, string tag);
    item_t it;
    it.due = cyc + off; it.h = h; it.l = l; it.p = p; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Watchdog
  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    item_t rst_it;
    rst_n = 1'b0;
    apply(1'b1, 1'b0, 1'b0, 1'b0);
    idle(3);
    rst_it.due = 0; rst_it.h = 2'b00; rst_it.l = 2'b00; rst_it.p = 2'b00;
    rst_it.tag = "R9 reset state";
    compare(rst_it);
    apply(1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    idle(2);

    // Lower-path brake from reset, first turn-on gap
    apply(1, 0, 0, 0);
    exp_at(1,   2'b00, 2'b00, 2'b00, "R9 no early turn-on");
    exp_at(D,   2'b00, 2'b00, 2'b00, "R9 gap after reset");
    exp_at(D+1, 2'b00, 2'b11, 2'b11, "R2 lower brake, R8 markers");
    exp_at(D+2, 2'b00, 2'b11, 2'b00, "R8 marker one cycle");
    idle(D+3);

    // Chop in lower brake has no effect
    apply(1, 0, 0, 1);
    exp_at(1,   2'b00, 2'b11, 2'b00, "R2 chop ignored");
    exp_at(D+1, 2'b00, 2'b11, 2'b00, "R2 chop ignored later");
    idle(D+2);

    // Forward
    apply(1, 1, 0, 0);
    exp_at(1,   2'b00, 2'b10, 2'b00, "R5 low opens next edge");
    exp_at(D,   2'b00, 2'b10, 2'b00, "R5 gap held");
    exp_at(D+1, 2'b01, 2'b10, 2'b00, "R4 forward");
    idle(D+2);

    // Chop in forward: synchronous rectification on leg 1
    apply(1, 1, 0, 1);
    exp_at(1,   2'b01, 2'b00, 2'b00, "R6 chop opens low");
    exp_at(D,   2'b01, 2'b00, 2'b00, "R6 chop gap");
    exp_at(D+1, 2'b11, 2'b00, 2'b00, "R6 upper recirculation");
    idle(D+2);

    // Chop release
    apply(1, 1, 0, 0);
    exp_at(1,   2'b01, 2'b00, 2'b00, "R6 release opens high");
    exp_at(D,   2'b01, 2'b00, 2'b00, "R6 release gap");
    exp_at(D+1, 2'b01, 2'b10, 2'b10, "R6 low back, R8 marker");
    exp_at(D+2, 2'b01, 2'b10, 2'b00, "R8 marker one cycle");
    idle(D+3);

    // Reverse: both legs swap
    apply(1, 0, 1, 0);
    exp_at(1,   2'b00, 2'b00, 2'b00, "R5 both legs open");
    exp_at(D+1, 2'b10, 2'b01, 2'b01, "R4 reverse");
    idle(D+2);

    // Upper brake with chop
    apply(1, 1, 1, 1);
    exp_at(1,   2'b10, 2'b00, 2'b00, "R3 leg0 gap");
    exp_at(D+1, 2'b11, 2'b00, 2'b00, "R3 upper brake");
    exp_at(D+3, 2'b11, 2'b00, 2'b00, "R3 chop ignored");
    idle(D+4);

    // Gap restart on leg 1 only
    apply(1, 0, 0, 0);
    exp_at(1, 2'b00, 2'b00, 2'b00, "R7 both open");
    exp_at(D, 2'b00, 2'b00, 2'b00, "R7 gap");
    idle(2);
    apply(1, 0, 1, 0);
    exp_at(D-1, 2'b00, 2'b01, 2'b01, "R7 unaffected leg on time");
    exp_at(D,   2'b00, 2'b01, 2'b00, "R7 restarted leg still off");
    exp_at(D+1, 2'b10, 2'b01, 2'b00, "R7 restarted leg on");
    idle(D+2);

    // Disable
    apply(0, 1, 1, 1);
    exp_at(1, 2'b00, 2'b00, 2'b00, "R1 disable");
    idle(2);
    apply(0, 1, 0, 0);
    exp_at(1,   2'b00, 2'b00, 2'b00, "R1 inputs ignored");
    exp_at(D+2, 2'b00, 2'b00, 2'b00, "R1 stays off");
    idle(D+3);

    // Re-enable forward from all-off
    apply(1, 1, 0, 0);
    exp_at(1,   2'b00, 2'b00, 2'b00, "R5 gap from off");
    exp_at(D,   2'b00, 2'b00, 2'b00, "R5 gap from off end");
    exp_at(D+1, 2'b01, 2'b10, 2'b10, "R4 forward, R8 marker");
    idle(D+2);

    while (q.size() > 0) idle(1);
    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule